// File: doc/BRIEF.md
# Lane-Addressable Vector Register File

This block is a bank of wide vector registers for a SIMD datapath. Each register can be handled as one whole vector or as a row of equal-width lanes. The lane width is chosen per access as 8, 16, 32 or 64 bits. A single synchronous write port can do one of four things:
- replace a whole register;
- insert one element into a single lane and leave the other lanes as they were;
- broadcast one scalar into every lane;
- write a scalar that occupies only the low part of the register and zeroes everything above it.

Two independent combinational read ports each return the full addressed vector. Each port also returns one extracted lane, zero-extended to 64 bits. Reading lane 0 at a given width gives the scalar view of a register at that width. An execution pipeline uses the file by driving the write controls from decode and by taking operands from the two read ports.

The block has no sequencing of its own. Its only state is the register contents, which change at the clock edge. The write merge and the lane extraction are purely combinational.

Top module: `vreg_lane_file`

## Requirements
- R1: The file holds 32 registers of 128 bits. An active-high synchronous reset clears every register to zero, and both read ports return zero in the cycle after reset.
- R2: Write operation code 1 (full) stores all 128 bits of the write data into the addressed register.
- R3: Write operation code 2 (insert) stores the low E bits of the write data into lane L of the register. Lane L occupies bits [L*E+E-1 : L*E], with lane 0 at the least significant end. Every other bit of the register keeps its value.
- R4: Write operation code 3 (broadcast) fills every lane of the register with the low E bits of the write data.
- R5: Write operation code 4 (scalar) stores the low E bits of the write data at bits [E-1:0] and clears all bits above them. Code 1 serves as the 128-bit scalar write.
- R6: The element-size code sets E: 0 gives 8 bits (16 lanes), 1 gives 16 bits (8 lanes), 2 gives 32 bits (4 lanes) and 3 gives 64 bits (2 lanes).
- R7: A lane index larger than the lane count for the chosen size is reduced to its low log2(lanes) bits, on both writes and reads.
- R8: The two read ports have their own index, size and lane inputs and operate independently. Each returns the full addressed register combinationally.
- R9: Each read port also outputs the selected lane, zero-extended to 64 bits. Lane 0 is the scalar view at that width.
- R10: A write takes effect at the rising clock edge. A read of the register being written in the same cycle returns the old contents.
- R11: Operation code 0 and codes 5 to 7 write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_op | input | 3 | Write operation code |
| wr_idx | input | 5 | Register written |
| wr_esize | input | 2 | Element-size code for the write |
| wr_lane | input | 4 | Lane index for insert |
| wr_data | input | 128 | Write data; the low E bits form the element |
| ra_idx | input | 5 | Port A register index |
| ra_esize | input | 2 | Port A element-size code |
| ra_lane | input | 4 | Port A lane index |
| ra_vec | output | 128 | Port A full register |
| ra_elem | output | 64 | Port A extracted lane |
| rb_idx | input | 5 | Port B register index |
| rb_esize | input | 2 | Port B element-size code |
| rb_lane | input | 4 | Port B lane index |
| rb_vec | output | 128 | Port B full register |
| rb_elem | output | 64 | Port B extracted lane |

## Verification
Whenever port A reads back the register written one cycle earlier, the assertions check the following on every cycle:
- an insert left every bit outside the targeted lane untouched;
- a scalar write left zeros above its width;
- a full write stored the data word;
- an ignored operation code left the register unchanged;
- a broadcast element comes back on the lane output at its size.

The exact placement of lanes for each size is shown only by the bench's scenarios. So are the masking of out-of-range lane indices, the old value seen by a same-cycle read, the independence of port B, and the clearing of earlier contents by a mid-run reset.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
    localparam int VEC_W   = 128;
    localparam int ELEM_W  = 64;
    localparam int N_SIZES = 4;
    localparam int LANE_IW = $clog2(VEC_W / 8);
    localparam int OFF_W   = $clog2(VEC_W);

    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_FULL   = 3'd1,
        OP_INSERT = 3'd2,
        OP_BCAST  = 3'd3,
        OP_SCALAR = 3'd4
    } vrf_op_e;

    // Ones in the low E bits for size code es.
    function automatic logic [ELEM_W-1:0] elem_mask(logic [1:0] es);
        if (es == 2'd3) return '1;
        return (ELEM_W'(1) << (8 << es)) - ELEM_W'(1);
    endfunction

    // Bit offset of lane ln at size code es, with the index reduced to the lane count.
    function automatic logic [OFF_W-1:0] lane_off(logic [1:0] es, logic [LANE_IW-1:0] ln);
        logic [LANE_IW-1:0] lim;
        lim = LANE_IW'((VEC_W >> (3 + es)) - 1);
        return OFF_W'(OFF_W'(ln & lim) << (3 + es));
    endfunction
endpackage

// File: rtl/vrf_lane_extract.sv
module vrf_lane_extract
    import vrf_pkg::*;
(
    input  logic [VEC_W-1:0]   vec_in,
    input  logic [1:0]         esize,
    input  logic [LANE_IW-1:0] lane,
    output logic [ELEM_W-1:0]  elem_out
);
    logic [OFF_W-1:0] off;

    always_comb begin
        off      = lane_off(esize, lane);
        elem_out = ELEM_W'(vec_in >> off) & elem_mask(esize);
    end
endmodule

// File: rtl/vrf_write_merge.sv
module vrf_write_merge
    import vrf_pkg::*;
(
    input  logic [VEC_W-1:0]   old_vec,
    input  logic [2:0]         op,
    input  logic [1:0]         esize,
    input  logic [LANE_IW-1:0] lane,
    input  logic [VEC_W-1:0]   wdata,
    output logic [VEC_W-1:0]   new_vec,
    output logic [VEC_W-1:0]   lane_msk,
    output logic               wr_en
);
    logic [N_SIZES-1:0][VEC_W-1:0] rep;
    logic [VEC_W-1:0]              ins_val;
    logic [VEC_W-1:0]              scal_val;
    logic [OFF_W-1:0]              off;

    // One replicated pattern per element size.
    for (genvar s = 0; s < N_SIZES; s++) begin : g_size
        localparam int EW = 8 << s;
        for (genvar k = 0; k < VEC_W / EW; k++) begin : g_lane
            assign rep[s][k*EW +: EW] = wdata[EW-1:0];
        end
    end

    always_comb begin
        off      = lane_off(esize, lane);
        scal_val = VEC_W'(wdata[ELEM_W-1:0] & elem_mask(esize));
        lane_msk = VEC_W'(elem_mask(esize)) << off;
        ins_val  = scal_val << off;
        wr_en    = 1'b1;
        unique case (op)
            OP_FULL:   new_vec = wdata;
            OP_INSERT: new_vec = (old_vec & ~lane_msk) | ins_val;
            OP_BCAST:  new_vec = rep[esize];
            OP_SCALAR: new_vec = scal_val;
            default: begin
                new_vec = old_vec;
                wr_en   = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/vreg_lane_file.sv
module vreg_lane_file
    import vrf_pkg::*;
#(
    parameter int NREGS = 32,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [2:0]           wr_op,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [1:0]           wr_esize,
    input  logic [LANE_IW-1:0]   wr_lane,
    input  logic [VEC_W-1:0]     wr_data,
    input  logic [IDX_W-1:0]     ra_idx,
    input  logic [1:0]           ra_esize,
    input  logic [LANE_IW-1:0]   ra_lane,
    output logic [VEC_W-1:0]     ra_vec,
    output logic [ELEM_W-1:0]    ra_elem,
    input  logic [IDX_W-1:0]     rb_idx,
    input  logic [1:0]           rb_esize,
    input  logic [LANE_IW-1:0]   rb_lane,
    output logic [VEC_W-1:0]     rb_vec,
    output logic [ELEM_W-1:0]    rb_elem
);
    logic [VEC_W-1:0] regs_q [NREGS];
    logic [VEC_W-1:0] old_vec;
    logic [VEC_W-1:0] new_vec;
    logic [VEC_W-1:0] lane_msk;
    logic             wr_en;

    assign old_vec = regs_q[wr_idx];

    vrf_write_merge u_merge (
        .old_vec (old_vec),
        .op      (wr_op),
        .esize   (wr_esize),
        .lane    (wr_lane),
        .wdata   (wr_data),
        .new_vec (new_vec),
        .lane_msk(lane_msk),
        .wr_en   (wr_en)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
        end else if (wr_en) begin
            regs_q[wr_idx] <= new_vec;
        end
    end

    assign ra_vec = regs_q[ra_idx];
    assign rb_vec = regs_q[rb_idx];

    vrf_lane_extract u_ext_a (
        .vec_in  (ra_vec),
        .esize   (ra_esize),
        .lane    (ra_lane),
        .elem_out(ra_elem)
    );

    vrf_lane_extract u_ext_b (
        .vec_in  (rb_vec),
        .esize   (rb_esize),
        .lane    (rb_lane),
        .elem_out(rb_elem)
    );

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (ra_vec == '0) && (rb_vec == '0));

    // R2
    full_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_op == OP_FULL) |=>
            ((ra_idx != $past(wr_idx)) || (ra_vec == $past(wr_data))));

    // R3
    insert_keeps_rest_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_op == OP_INSERT) |=>
            ((ra_idx != $past(wr_idx)) ||
             (((ra_vec ^ $past(old_vec)) & ~$past(lane_msk)) == '0)));

    // R4
    bcast_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_op == OP_BCAST) |=>
            ((ra_idx != $past(wr_idx)) || (ra_esize != $past(wr_esize)) ||
             (ra_elem == ($past(wr_data[ELEM_W-1:0]) & elem_mask(ra_esize)))));

    // R5
    scalar_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_op == OP_SCALAR) |=>
            ((ra_idx != $past(wr_idx)) ||
             ((ra_vec & ~VEC_W'(elem_mask($past(wr_esize)))) == '0)));

    // R11
    idle_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        ((wr_op == OP_IDLE) || (wr_op > OP_SCALAR)) |=>
            ((ra_idx != $past(wr_idx)) || (ra_vec == $past(old_vec))));
endmodule

// File: tb/vreg_lane_file_test.sv
`timescale 1ns/1ps
module vreg_lane_file_test;
    import vrf_pkg::*;

    typedef struct packed {
        logic [2:0]   op;
        logic [4:0]   idx;
        logic [1:0]   es;
        logic [3:0]   lane;
        logic [127:0] data;
        logic [4:0]   cidx;
        logic [1:0]   ces;
        logic [3:0]   clane;
        logic [127:0] evec;
        logic [63:0]  eelem;
    } step_t;

    localparam int NSTEP = 10;
    localparam step_t TBL [NSTEP] = '{
        // R2, R9: full write, read 32-bit lane 1
        '{3'd1, 5'd3, 2'd2, 4'd0, 128'h00112233_44556677_8899AABB_CCDDEEFF,
          5'd3, 2'd2, 4'd1, 128'h00112233_44556677_8899AABB_CCDDEEFF, 64'h8899AABB},
        // R3, R6: byte insert into lane 5
        '{3'd2, 5'd3, 2'd0, 4'd5, 128'h1234_00A5,
          5'd3, 2'd0, 4'd5, 128'h00112233_44556677_8899A5BB_CCDDEEFF, 64'hA5},
        // R7: 32-bit insert with lane 6 reduced to lane 2
        '{3'd2, 5'd3, 2'd2, 4'd6, 128'hDEADBEEF,
          5'd3, 2'd2, 4'd2, 128'h00112233_DEADBEEF_8899A5BB_CCDDEEFF, 64'hDEADBEEF},
        // R4: 16-bit broadcast
        '{3'd3, 5'd7, 2'd1, 4'd0, 128'hABCD,
          5'd7, 2'd1, 4'd7, {8{16'hABCD}}, 64'hABCD},
        // R4: 64-bit broadcast
        '{3'd3, 5'd7, 2'd3, 4'd0, 128'h01234567_89ABCDEF,
          5'd7, 2'd3, 4'd1, {2{64'h01234567_89ABCDEF}}, 64'h01234567_89ABCDEF},
        // R5: 16-bit scalar write clears the rest
        '{3'd4, 5'd3, 2'd1, 4'd0, 128'h1111_2222_BEEF,
          5'd3, 2'd0, 4'd1, 128'hBEEF, 64'hBE},
        // R11: op 0 writes nothing
        '{3'd0, 5'd3, 2'd0, 4'd0, {128{1'b1}},
          5'd3, 2'd1, 4'd0, 128'hBEEF, 64'hBEEF},
        // R11: op 5 writes nothing
        '{3'd5, 5'd3, 2'd3, 4'd0, {128{1'b1}},
          5'd3, 2'd1, 4'd0, 128'hBEEF, 64'hBEEF},
        // R3, R7: 64-bit insert, lane 3 reduced to lane 1
        '{3'd2, 5'd31, 2'd3, 4'd3, 128'hCAFEF00D_12345678,
          5'd31, 2'd3, 4'd0, {64'hCAFEF00D_12345678, 64'h0}, 64'h0},
        // R4, R6: byte broadcast read back at 16 bits
        '{3'd3, 5'd0, 2'd0, 4'd0, 128'h5A,
          5'd0, 2'd1, 4'd3, {16{8'h5A}}, 64'h5A5A}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [2:0]   wr_op = 3'd0;
    logic [4:0]   wr_idx = '0;
    logic [1:0]   wr_esize = '0;
    logic [3:0]   wr_lane = '0;
    logic [127:0] wr_data = '0;
    logic [4:0]   ra_idx = '0, rb_idx = '0;
    logic [1:0]   ra_esize = '0, rb_esize = '0;
    logic [3:0]   ra_lane = '0, rb_lane = '0;
    logic [127:0] ra_vec, rb_vec;
    logic [63:0]  ra_elem, rb_elem;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    vreg_lane_file uut (
        .clk(clk), .rst(rst),
        .wr_op(wr_op), .wr_idx(wr_idx), .wr_esize(wr_esize),
        .wr_lane(wr_lane), .wr_data(wr_data),
        .ra_idx(ra_idx), .ra_esize(ra_esize), .ra_lane(ra_lane),
        .ra_vec(ra_vec), .ra_elem(ra_elem),
        .rb_idx(rb_idx), .rb_esize(rb_esize), .rb_lane(rb_lane),
        .rb_vec(rb_vec), .rb_elem(rb_elem)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #40000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1: reset state seen on both ports
        ra_idx = 5'd3; rb_idx = 5'd31; #1;
        check("R1", ra_vec, '0);
        check("R1", rb_vec, '0);

        for (int i = 0; i < NSTEP; i++) begin
            @(negedge clk);
            wr_op = TBL[i].op; wr_idx = TBL[i].idx; wr_esize = TBL[i].es;
            wr_lane = TBL[i].lane; wr_data = TBL[i].data;
            ra_idx = TBL[i].cidx; ra_esize = TBL[i].ces; ra_lane = TBL[i].clane;
            @(posedge clk); #1;
            wr_op = 3'd0; #1;
            check($sformatf("R2-R11 step %0d vec", i), ra_vec, TBL[i].evec);
            check($sformatf("R9 step %0d elem", i), 128'(ra_elem), 128'(TBL[i].eelem));
        end

        // R10: same-cycle read returns old contents, new ones after the edge
        @(negedge clk);
        wr_op = 3'd1; wr_idx = 5'd9; wr_data = {4{32'h600DF00D}};
        ra_idx = 5'd9; #1;
        check("R10 old", ra_vec, '0);
        @(posedge clk); #1;
        wr_op = 3'd0; #1;
        check("R10 new", ra_vec, {4{32'h600DF00D}});

        // R8: port B reads independently of port A
        rb_idx = 5'd31; rb_esize = 2'd3; rb_lane = 4'd1; ra_idx = 5'd3; #1;
        check("R8 b vec", rb_vec, {64'hCAFEF00D_12345678, 64'h0});
        check("R8 b elem", 128'(rb_elem), 128'h0000_0000_0000_0000_CAFEF00D_12345678);
        check("R8 a vec", ra_vec, 128'hBEEF);

        // R9: scalar view at 32 bits is lane 0 of register 9
        rb_idx = 5'd9; rb_esize = 2'd2; rb_lane = 4'd0; #1;
        check("R9 scalar view", 128'(rb_elem), 128'h600DF00D);

        // R1: reset in mid-run clears everything written
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        ra_idx = 5'd7; rb_idx = 5'd9; #1;
        check("R1 mid a", ra_vec, '0);
        check("R1 mid b", rb_vec, '0);
        ra_idx = 5'd3; rb_idx = 5'd31; #1;
        check("R1 mid a3", ra_vec, '0);
        check("R1 mid b31", rb_vec, '0);

        finish_run();
    end
endmodule